// File: doc/BRIEF.md
# Command/Response Data FIFO Controller

This block sits behind the register decoder of a security-module host interface. It holds the command state machine of every locality and the byte buffer that carries commands in and responses out. The host picks a locality and says whether that locality is currently the owner. It then writes command bytes one at a time through a data port, starts execution with a go strobe, and reads the response back through the same port. Arbitration between localities happens outside the block. Here it appears only as the `host_active` qualifier.

The block works out from the header of each command when the command is complete. Header bytes 2 to 5 hold the total length as a big-endian 32-bit value. The block reports five status flags and a burst count:

| Flag | Meaning |
|------|---------|
| more-expected | more command bytes are needed |
| status-valid | the status flags are meaningful |
| data-available | response bytes are waiting |
| command-ready | the locality is ready for a command |
| self-test-done | the backend has finished its self-test |

The backend engine is modelled as a level request with a length. The engine writes its response into the shared buffer and then pulses done. Three one-cycle event pulses, each tagged with a locality, feed an interrupt unit elsewhere.

Top module: `cmd_resp_fifo`

## Requirements
- R1: After reset every locality is idle and its flags are clear. The state code is 0 idle, 1 ready, 2 reception, 3 execution and 4 completion. The burst count equals the buffer depth.
- R2: A command-ready strobe (control value 3'b001) in idle moves the locality to ready. It sets command-ready and pulses `evt_cmd_ready` with `evt_loc` naming the locality.
- R3: The first data write in ready moves the locality to reception and sets more-expected and status-valid. Data writes in idle, execution or completion change nothing.
- R4: Once more than 5 bytes are held, more-expected stays set while the declared length exceeds the byte count. It clears on the byte that reaches that length, and status-valid stays set.
- R5: A data write with the buffer full stores nothing. It clears more-expected and keeps status-valid.
- R6: A go strobe (3'b010) starts execution only in reception with more-expected clear. Starting raises `be_req` with `be_len` equal to the byte count. In every other case the strobe is ignored.
- R7: `be_done` moves the executing locality to completion and sets status-valid and data-available. It rewinds the offset and pulses `evt_data_avail` and `evt_sts_valid`.
- R8: Data reads return response bytes in order only in completion while data-available is set. Otherwise they return 8'hFF. Reading the byte at the response length clamped to the depth clears data-available and keeps status-valid.
- R9: A retry strobe (3'b100) in completion rewinds to the first response byte and sets data-available again. A command-ready strobe in completion moves to ready, sets command-ready and clears data-available.
- R10: Command-ready in reception aborts at once to ready with an empty buffer. In execution it pulses `be_cancel`, and the following `be_done` returns the locality to ready with command-ready set instead of completion.
- R11: Control writes whose value is not exactly one set bit are ignored. Every access made while `host_active` is low is ignored.
- R12: The burst count is the number of unread response bytes while data-available is set, and the free buffer space otherwise. With `sts_narrow` high it is capped at 255.
- R13: The family field always reads the `FAMILY` parameter. Once a done with `be_selftest` has been seen, self-test-done stays set in every locality through all later status changes until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_loc | input | LOC_W | Locality of the current host access |
| host_active | input | 1 | The addressed locality owns the interface |
| ctl_wr | input | 1 | Control strobe write |
| ctl_wdata | input | 3 | Control value: bit0 command-ready, bit1 go, bit2 retry |
| data_wr | input | 1 | Data byte write |
| data_wdata | input | 8 | Data byte to write |
| data_rd | input | 1 | Data byte read; advances the offset |
| data_rdata | output | 8 | Byte returned for a read in this cycle |
| sts_narrow | input | 1 | Status is read with a 1-byte access |
| st_state | output | 3 | State of the addressed locality |
| st_family | output | 2 | Family field |
| st_selftest | output | 1 | Self-test done |
| st_more | output | 1 | More command bytes expected |
| st_valid | output | 1 | Status valid |
| st_avail | output | 1 | Response data available |
| st_cready | output | 1 | Command ready |
| burst_cnt | output | OW | Burst count |
| evt_cmd_ready | output | 1 | Command-ready event pulse |
| evt_data_avail | output | 1 | Data-available event pulse |
| evt_sts_valid | output | 1 | Status-valid event pulse |
| evt_loc | output | LOC_W | Locality of the event pulses |
| be_req | output | 1 | Backend execution request (level) |
| be_cancel | output | 1 | Backend cancel pulse |
| be_len | output | OW | Command length handed to the backend |
| be_loc | output | LOC_W | Locality being executed |
| be_done | input | 1 | Backend finished |
| be_selftest | input | 1 | Backend reports the self-test as done, sampled with `be_done` |
| be_wr | input | 1 | Backend response byte write |
| be_waddr | input | AW | Backend response byte address |
| be_wdata | input | 8 | Backend response byte |

## Verification
Some rules are checked on every cycle as invariants:
- more-expected only appears in reception together with status-valid.
- data-available only appears in completion.
- a rising `be_req` always follows an accepted go strobe.
- the request drops after done, and cancel is only raised while a request is open.
- the narrow burst cap holds.
- self-test-done is sticky.
- malformed control values leave the state untouched.

Other behaviours need whole scenarios from the bench: length parsing against the header, the response byte order, the retry rewind, both abort paths, buffer overflow, and the burst count values.

// File: rtl/cmdfifo_pkg.sv
package cmdfifo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READY = 3'd1,
        ST_RECV  = 3'd2,
        ST_EXEC  = 3'd3,
        ST_COMPL = 3'd4
    } fsm_e;

    typedef struct packed {
        logic [1:0] family;
        logic       selftest;
        logic       need_more;
        logic       valid;
        logic       avail;
        logic       cready;
    } sts_t;

    localparam logic [2:0] CTL_CREADY = 3'b001;
    localparam logic [2:0] CTL_GO     = 3'b010;
    localparam logic [2:0] CTL_RETRY  = 3'b100;
    localparam logic [7:0] NO_DATA    = 8'hFF;
    localparam int         HDR_BYTES  = 6;

    // Rewrite the volatile flags, keeping family and self-test bits.
    function automatic sts_t sts_set(sts_t s, logic m, logic v, logic a, logic c);
        sts_t r;
        r           = '0;
        r.family    = s.family;
        r.selftest  = s.selftest;
        r.need_more = m;
        r.valid     = v;
        r.avail     = a;
        r.cready    = c;
        return r;
    endfunction

    // Overlay the byte being written onto the big-endian length field.
    function automatic logic [31:0] len_merge(logic [31:0] cur, int unsigned idx,
                                              logic [7:0] b);
        logic [31:0] r;
        r = cur;
        case (idx)
            2: r[31:24] = b;
            3: r[23:16] = b;
            4: r[15:8]  = b;
            5: r[7:0]   = b;
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cmdfifo_buf.sv
module cmdfifo_buf #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          h_we,
    input  logic [AW-1:0] h_addr,
    input  logic [7:0]    h_wdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [7:0]    b_wdata,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic [31:0]   hdr_len
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (b_we)      mem[b_addr] <= b_wdata;
        else if (h_we) mem[h_addr] <= h_wdata;
    end

    assign rd_data = mem[rd_addr];
    assign hdr_len = {mem[2], mem[3], mem[4], mem[5]};
endmodule

// File: rtl/cmdfifo_burst.sv
module cmdfifo_burst #(
    parameter int DEPTH = 1024,
    parameter int OW    = $clog2(DEPTH + 1)
) (
    input  logic          active,
    input  logic          avail,
    input  logic [OW-1:0] off,
    input  logic [OW-1:0] resp_len,
    input  logic          narrow,
    output logic [OW-1:0] cnt
);
    localparam logic [OW-1:0] CAP = OW'(255);
    logic [OW-1:0] rem;

    always_comb begin
        if (!active)     rem = '0;
        else if (avail)  rem = (resp_len > off) ? resp_len - off : '0;
        else             rem = OW'(DEPTH) - off;
        cnt = (narrow && rem > CAP) ? CAP : rem;
    end
endmodule

// File: rtl/cmdfifo_ctrl.sv
module cmdfifo_ctrl
    import cmdfifo_pkg::*;
#(
    parameter int         NLOC   = 5,
    parameter int         LOC_W  = 3,
    parameter int         DEPTH  = 1024,
    parameter int         OW     = $clog2(DEPTH + 1),
    parameter logic [1:0] FAMILY = 2'b01
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LOC_W-1:0] host_loc,
    input  logic             host_active,
    input  logic             ctl_wr,
    input  logic [2:0]       ctl_wdata,
    input  logic             data_wr,
    input  logic [7:0]       data_wdata,
    input  logic             data_rd,
    input  logic             be_done,
    input  logic             be_selftest,
    input  logic [31:0]      hdr_len,
    output logic             host_ok,
    output logic             mem_we,
    output logic [OW-1:0]    off,
    output logic [OW-1:0]    resp_len,
    output fsm_e             cur_state,
    output sts_t             cur_sts,
    output logic             be_req,
    output logic             be_cancel,
    output logic [OW-1:0]    be_len,
    output logic [LOC_W-1:0] be_loc,
    output logic             evt_cmd_ready,
    output logic             evt_data_avail,
    output logic             evt_sts_valid,
    output logic [LOC_W-1:0] evt_loc
);
    fsm_e             state_q [NLOC];
    fsm_e             state_d [NLOC];
    sts_t             sts_q   [NLOC];
    sts_t             sts_d   [NLOC];
    logic [OW-1:0]    off_q, off_d, len_q, len_d, newoff;
    logic             busy_q, busy_d, abort_q, abort_d, cancel_d;
    logic [LOC_W-1:0] xloc_q, xloc_d, li, eloc_d;
    logic             ecr_d, eav_d, esv_d;
    logic [31:0]      merged_len;

    assign host_ok  = host_active && (32'(host_loc) < NLOC);
    assign li       = host_ok ? host_loc : '0;
    assign newoff   = off_q + OW'(1);
    assign resp_len = (hdr_len > 32'(DEPTH)) ? OW'(DEPTH) : hdr_len[OW-1:0];
    assign merged_len = len_merge(hdr_len, 32'(off_q), data_wdata);

    always_comb begin
        state_d  = state_q;
        sts_d    = sts_q;
        off_d    = off_q;
        len_d    = len_q;
        busy_d   = busy_q;
        abort_d  = abort_q;
        xloc_d   = xloc_q;
        cancel_d = 1'b0;
        mem_we   = 1'b0;
        ecr_d    = 1'b0;
        eav_d    = 1'b0;
        esv_d    = 1'b0;
        eloc_d   = '0;

        // backend completion
        if (be_done && busy_q) begin
            if (be_selftest)
                for (int l = 0; l < NLOC; l++) sts_d[l].selftest = 1'b1;
            if (abort_q) begin
                state_d[xloc_q] = ST_READY;
                sts_d[xloc_q]   = sts_set(sts_d[xloc_q], 1'b0, 1'b0, 1'b0, 1'b1);
                ecr_d           = 1'b1;
            end else begin
                state_d[xloc_q] = ST_COMPL;
                sts_d[xloc_q]   = sts_set(sts_d[xloc_q], 1'b0, 1'b1, 1'b1, 1'b0);
                eav_d           = 1'b1;
                esv_d           = 1'b1;
            end
            eloc_d  = xloc_q;
            off_d   = '0;
            busy_d  = 1'b0;
            abort_d = 1'b0;
        end

        // host access
        if (host_ok) begin
            if (ctl_wr) begin
                if (ctl_wdata == CTL_CREADY) begin
                    case (state_d[li])
                        ST_IDLE, ST_RECV: begin
                            state_d[li] = ST_READY;
                            sts_d[li]   = sts_set(sts_d[li], 1'b0, 1'b0, 1'b0, 1'b1);
                            off_d       = '0;
                            ecr_d       = 1'b1;
                            eloc_d      = li;
                        end
                        ST_READY: off_d = '0;
                        ST_EXEC: begin
                            if (!abort_q) begin
                                abort_d  = 1'b1;
                                cancel_d = 1'b1;
                            end
                        end
                        ST_COMPL: begin
                            state_d[li] = ST_READY;
                            off_d       = '0;
                            if (!sts_d[li].cready) begin
                                sts_d[li] = sts_set(sts_d[li], 1'b0, 1'b0, 1'b0, 1'b1);
                                ecr_d     = 1'b1;
                                eloc_d    = li;
                            end
                            sts_d[li].avail = 1'b0;
                        end
                        default: ;
                    endcase
                end else if (ctl_wdata == CTL_GO) begin
                    if (state_d[li] == ST_RECV && !sts_d[li].need_more) begin
                        state_d[li] = ST_EXEC;
                        busy_d      = 1'b1;
                        xloc_d      = li;
                        len_d       = off_q;
                    end
                end else if (ctl_wdata == CTL_RETRY) begin
                    if (state_d[li] == ST_COMPL) begin
                        off_d     = '0;
                        sts_d[li] = sts_set(sts_d[li], 1'b0, 1'b1, 1'b1, 1'b0);
                    end
                end
            end else if (data_wr) begin
                if (state_d[li] == ST_READY) begin
                    state_d[li] = ST_RECV;
                    sts_d[li]   = sts_set(sts_d[li], 1'b1, 1'b1, 1'b0, 1'b0);
                end
                if (state_d[li] == ST_RECV && sts_d[li].need_more) begin
                    if (off_q < OW'(DEPTH)) begin
                        mem_we = 1'b1;
                        off_d  = newoff;
                        if (newoff > OW'(HDR_BYTES - 1)) begin
                            if (!sts_d[li].valid) begin
                                esv_d  = 1'b1;
                                eloc_d = li;
                            end
                            sts_d[li] = sts_set(sts_d[li], merged_len > 32'(newoff),
                                                1'b1, 1'b0, 1'b0);
                        end
                    end else begin
                        sts_d[li] = sts_set(sts_d[li], 1'b0, 1'b1, 1'b0, 1'b0);
                    end
                end
            end else if (data_rd) begin
                if (state_d[li] == ST_COMPL && sts_d[li].avail) begin
                    off_d = newoff;
                    if (newoff >= resp_len) begin
                        sts_d[li] = sts_set(sts_d[li], 1'b0, 1'b1, 1'b0, 1'b0);
                        esv_d     = 1'b1;
                        eloc_d    = li;
                    end
                end
            end
        end
    end

    for (genvar g = 0; g < NLOC; g++) begin : g_loc
        always_ff @(posedge clk) begin
            if (rst) begin
                state_q[g] <= ST_IDLE;
                sts_q[g]   <= sts_t'{family: FAMILY, default: 1'b0};
            end else begin
                state_q[g] <= state_d[g];
                sts_q[g]   <= sts_d[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q          <= '0;
            len_q          <= '0;
            busy_q         <= 1'b0;
            abort_q        <= 1'b0;
            xloc_q         <= '0;
            be_cancel      <= 1'b0;
            evt_cmd_ready  <= 1'b0;
            evt_data_avail <= 1'b0;
            evt_sts_valid  <= 1'b0;
            evt_loc        <= '0;
        end else begin
            off_q          <= off_d;
            len_q          <= len_d;
            busy_q         <= busy_d;
            abort_q        <= abort_d;
            xloc_q         <= xloc_d;
            be_cancel      <= cancel_d;
            evt_cmd_ready  <= ecr_d;
            evt_data_avail <= eav_d;
            evt_sts_valid  <= esv_d;
            evt_loc        <= eloc_d;
        end
    end

    assign off       = off_q;
    assign be_req    = busy_q;
    assign be_len    = len_q;
    assign be_loc    = xloc_q;
    assign cur_state = host_ok ? state_q[li] : ST_IDLE;
    assign cur_sts   = host_ok ? sts_q[li] : '0;
endmodule

// File: rtl/cmd_resp_fifo.sv
module cmd_resp_fifo
    import cmdfifo_pkg::*;
#(
    parameter int         DEPTH  = 1024,
    parameter int         NLOC   = 5,
    parameter logic [1:0] FAMILY = 2'b01,
    localparam int        AW     = $clog2(DEPTH),
    localparam int        OW     = $clog2(DEPTH + 1),
    localparam int        LOC_W  = (NLOC > 1) ? $clog2(NLOC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LOC_W-1:0] host_loc,
    input  logic             host_active,
    input  logic             ctl_wr,
    input  logic [2:0]       ctl_wdata,
    input  logic             data_wr,
    input  logic [7:0]       data_wdata,
    input  logic             data_rd,
    output logic [7:0]       data_rdata,
    input  logic             sts_narrow,
    output logic [2:0]       st_state,
    output logic [1:0]       st_family,
    output logic             st_selftest,
    output logic             st_more,
    output logic             st_valid,
    output logic             st_avail,
    output logic             st_cready,
    output logic [OW-1:0]    burst_cnt,
    output logic             evt_cmd_ready,
    output logic             evt_data_avail,
    output logic             evt_sts_valid,
    output logic [LOC_W-1:0] evt_loc,
    output logic             be_req,
    output logic             be_cancel,
    output logic [OW-1:0]    be_len,
    output logic [LOC_W-1:0] be_loc,
    input  logic             be_done,
    input  logic             be_selftest,
    input  logic             be_wr,
    input  logic [AW-1:0]    be_waddr,
    input  logic [7:0]       be_wdata
);
    logic          host_ok, mem_we;
    logic [OW-1:0] off, resp_len;
    logic [7:0]    rd_data;
    logic [31:0]   hdr_len;
    fsm_e          cur_state;
    sts_t          cur_sts;

    cmdfifo_ctrl #(.NLOC(NLOC), .LOC_W(LOC_W), .DEPTH(DEPTH), .OW(OW), .FAMILY(FAMILY)) u_ctrl (
        .clk(clk), .rst(rst), .host_loc(host_loc), .host_active(host_active),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .data_wr(data_wr), .data_wdata(data_wdata),
        .data_rd(data_rd), .be_done(be_done), .be_selftest(be_selftest), .hdr_len(hdr_len),
        .host_ok(host_ok), .mem_we(mem_we), .off(off), .resp_len(resp_len),
        .cur_state(cur_state), .cur_sts(cur_sts), .be_req(be_req), .be_cancel(be_cancel),
        .be_len(be_len), .be_loc(be_loc), .evt_cmd_ready(evt_cmd_ready),
        .evt_data_avail(evt_data_avail), .evt_sts_valid(evt_sts_valid), .evt_loc(evt_loc)
    );

    cmdfifo_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
        .clk(clk), .h_we(mem_we), .h_addr(off[AW-1:0]), .h_wdata(data_wdata),
        .b_we(be_wr), .b_addr(be_waddr), .b_wdata(be_wdata),
        .rd_addr(off[AW-1:0]), .rd_data(rd_data), .hdr_len(hdr_len)
    );

    cmdfifo_burst #(.DEPTH(DEPTH), .OW(OW)) u_burst (
        .active(host_ok), .avail(cur_sts.avail), .off(off), .resp_len(resp_len),
        .narrow(sts_narrow), .cnt(burst_cnt)
    );

    assign data_rdata  = (cur_state == ST_COMPL && cur_sts.avail) ? rd_data : NO_DATA;
    assign st_state    = cur_state;
    assign st_family   = cur_sts.family;
    assign st_selftest = cur_sts.selftest;
    assign st_more     = cur_sts.need_more;
    assign st_valid    = cur_sts.valid;
    assign st_avail    = cur_sts.avail;
    assign st_cready   = cur_sts.cready;
endmodule

// File: rtl/cmdfifo_checker.sv
module cmdfifo_checker #(
    parameter int OW    = 11,
    parameter int LOC_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [LOC_W-1:0] host_loc,
    input logic             host_active,
    input logic             ctl_wr,
    input logic [2:0]       ctl_wdata,
    input logic             sts_narrow,
    input logic [2:0]       st_state,
    input logic             st_selftest,
    input logic             st_more,
    input logic             st_valid,
    input logic             st_avail,
    input logic [OW-1:0]    burst_cnt,
    input logic             be_req,
    input logic             be_cancel,
    input logic             be_done
);
    a_r4_more_in_recv: assert property (@(posedge clk) disable iff (rst)
        st_more |-> (st_valid && st_state == 3'd2));

    a_r7_avail_in_compl: assert property (@(posedge clk) disable iff (rst)
        st_avail |-> (st_valid && st_state == 3'd4));

    a_r6_go_starts: assert property (@(posedge clk) disable iff (rst)
        $rose(be_req) |-> $past(ctl_wr && host_active && ctl_wdata == 3'b010 &&
                                st_state == 3'd2 && !st_more));

    a_r7_done_drops_req: assert property (@(posedge clk) disable iff (rst)
        (be_done && be_req) |=> !be_req);

    a_r10_cancel_in_exec: assert property (@(posedge clk) disable iff (rst)
        be_cancel |-> be_req);

    a_r11_bad_ctl_ignored: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && host_active && $countones(ctl_wdata) != 1 && !be_done)
        |=> (!$stable(host_loc) || st_state == $past(st_state)));

    a_r12_narrow_cap: assert property (@(posedge clk) disable iff (rst)
        sts_narrow |-> (burst_cnt <= OW'(255)));

    a_r13_selftest_sticky: assert property (@(posedge clk) disable iff (rst)
        (host_active && $past(host_active) && $stable(host_loc) && $past(st_selftest))
        |-> st_selftest);
endmodule

bind cmd_resp_fifo cmdfifo_checker #(.OW(OW), .LOC_W(LOC_W)) i_chk (
    .clk(clk), .rst(rst), .host_loc(host_loc), .host_active(host_active),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .sts_narrow(sts_narrow),
    .st_state(st_state), .st_selftest(st_selftest), .st_more(st_more),
    .st_valid(st_valid), .st_avail(st_avail), .burst_cnt(burst_cnt),
    .be_req(be_req), .be_cancel(be_cancel), .be_done(be_done)
);

// File: tb/test_cmd_resp_fifo.sv
module test_cmd_resp_fifo;
    localparam int         DEPTH  = 1024;
    localparam int         NLOC   = 5;
    localparam logic [1:0] FAM    = 2'b10;
    localparam int         AW     = $clog2(DEPTH);
    localparam int         OW     = $clog2(DEPTH + 1);
    localparam int         LOC_W  = 3;
    localparam logic [2:0] CR = 3'b001, GO = 3'b010, RT = 3'b100;

    logic clk = 1'b0, rst = 1'b1;
    logic [LOC_W-1:0] host_loc = '0;
    logic host_active = 1'b1, ctl_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0, sts_narrow = 1'b0;
    logic [2:0] ctl_wdata = '0;
    logic [7:0] data_wdata = '0, data_rdata;
    logic [2:0] st_state;
    logic [1:0] st_family;
    logic st_selftest, st_more, st_valid, st_avail, st_cready;
    logic [OW-1:0] burst_cnt, be_len;
    logic evt_cmd_ready, evt_data_avail, evt_sts_valid, be_req, be_cancel;
    logic [LOC_W-1:0] evt_loc, be_loc;
    logic be_done = 1'b0, be_selftest = 1'b0, be_wr = 1'b0;
    logic [AW-1:0] be_waddr = '0;
    logic [7:0] be_wdata = '0;

    int checks = 0, fails = 0;
    bit finished = 0;
    int exp_state [NLOC];
    logic [7:0] resp [64];
    int unsigned seed = 32'h1D2C;

    always #10 clk = ~clk;

    cmd_resp_fifo #(.DEPTH(DEPTH), .NLOC(NLOC), .FAMILY(FAM)) i_cmd_resp_fifo (.*);

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic op_ctl(int loc, logic [2:0] v, bit act = 1);
        @(negedge clk);
        host_loc = LOC_W'(loc); host_active = act; ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0; host_active = 1'b1;
    endtask

    task automatic op_wr(int loc, logic [7:0] b);
        @(negedge clk);
        host_loc = LOC_W'(loc); data_wr = 1'b1; data_wdata = b;
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    task automatic op_rd(int loc, output logic [7:0] b);
        @(negedge clk);
        host_loc = LOC_W'(loc); data_rd = 1'b1;
        #1 b = data_rdata;
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    function automatic logic [7:0] hdr_byte(int idx, int len);
        logic [31:0] l = 32'(len);
        case (idx)
            2: return l[31:24];
            3: return l[23:16];
            4: return l[15:8];
            5: return l[7:0];
            default: return 8'(idx * 7 + 3);
        endcase
    endfunction

    task automatic backend(int n, bit st);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            be_wr = 1'b1; be_waddr = AW'(j); be_wdata = resp[j];
        end
        @(negedge clk);
        be_wr = 1'b0; be_done = 1'b1; be_selftest = st;
        @(negedge clk);
        be_done = 1'b0; be_selftest = 1'b0;
    endtask

    task automatic make_resp(int n);
        for (int j = 0; j < n; j++)
            resp[j] = (j >= 2 && j <= 5) ? hdr_byte(j, n) : 8'($urandom_range(0, 255));
    endtask

    task automatic send_cmd(int loc, int len);
        if (exp_state[loc] == 0) begin
            op_ctl(loc, CR);
            chk("R2", "state after cready", int'(st_state), 1);
            chk("R2", "cready event", int'(evt_cmd_ready), 1);
            chk("R2", "event locality", int'(evt_loc), loc);
        end
        for (int i = 0; i < len; i++) begin
            op_wr(loc, hdr_byte(i, len));
            if (i == 0) chk("R3", "state after first byte", int'(st_state), 2);
            chk("R4", "more-expected", int'(st_more), (i + 1 <= 5) ? 1 : int'(len > i + 1));
            chk("R12", "free space", int'(burst_cnt), DEPTH - i - 1);
        end
        chk("R4", "valid at end", int'(st_valid), 1);
    endtask

    task automatic read_resp(int loc, int n, string req);
        logic [7:0] b;
        for (int j = 0; j < n; j++) begin
            if (j == 1) chk("R12", "remaining response", int'(burst_cnt), n - 1);
            op_rd(loc, b);
            chk(req, "response byte", int'(b), int'(resp[j]));
        end
        chk("R8", "avail after last", int'(st_avail), 0);
        chk("R8", "valid after last", int'(st_valid), 1);
        op_rd(loc, b);
        chk("R8", "no-data byte", int'(b), 255);
    endtask

    task automatic full_cycle(int loc, int len, int n, bit retry, bit st);
        logic [7:0] b;
        send_cmd(loc, len);
        op_ctl(loc, GO);
        chk("R6", "be_req", int'(be_req), 1);
        chk("R6", "be_len", int'(be_len), len);
        chk("R6", "be_loc", int'(be_loc), loc);
        make_resp(n);
        backend(n, st);
        chk("R7", "state completion", int'(st_state), 4);
        chk("R7", "avail", int'(st_avail), 1);
        chk("R7", "data event", int'(evt_data_avail), 1);
        chk("R7", "valid event", int'(evt_sts_valid), 1);
        chk("R12", "burst = response length", int'(burst_cnt), n);
        read_resp(loc, n, "R8");
        if (retry) begin
            op_ctl(loc, RT);
            chk("R9", "avail after retry", int'(st_avail), 1);
            op_rd(loc, b);
            chk("R9", "first byte again", int'(b), int'(resp[0]));
        end
        op_ctl(loc, CR);
        chk("R9", "ready from completion", int'(st_state), 1);
        chk("R9", "avail cleared", int'(st_avail), 0);
        chk("R9", "cready set", int'(st_cready), 1);
        exp_state[loc] = 1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        void'($urandom(seed));
        for (int l = 0; l < NLOC; l++) exp_state[l] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset state", int'(st_state), 0);
        chk("R1", "reset flags", int'({st_more, st_valid, st_avail, st_cready, st_selftest}), 0);
        chk("R1", "reset burst", int'(burst_cnt), DEPTH);
        chk("R13", "family", int'(st_family), int'(FAM));

        op_wr(0, 8'h55);
        chk("R3", "idle write dropped", int'(st_state), 0);
        chk("R3", "idle write no space used", int'(burst_cnt), DEPTH);

        op_ctl(0, 3'b011);
        chk("R11", "multi-bit ignored", int'(st_state), 0);
        op_ctl(1, CR, 0);
        host_loc = 3'd1; #1;
        chk("R11", "inactive access ignored", int'(st_state), 0);

        op_ctl(0, CR);
        chk("R2", "idle to ready", int'(st_state), 1);
        chk("R2", "cready flag", int'(st_cready), 1);
        chk("R2", "cready event", int'(evt_cmd_ready), 1);
        exp_state[0] = 1;
        op_ctl(0, GO);
        chk("R6", "go in ready ignored", int'(st_state), 1);
        chk("R6", "no request", int'(be_req), 0);

        sts_narrow = 1'b1; #1;
        chk("R12", "narrow cap", int'(burst_cnt), 255);
        sts_narrow = 1'b0; #1;
        chk("R12", "wide count", int'(burst_cnt), DEPTH);

        for (int i = 0; i < 3; i++) op_wr(0, 8'(i));
        op_ctl(0, CR);
        chk("R10", "abort reception to ready", int'(st_state), 1);
        chk("R10", "buffer emptied", int'(burst_cnt), DEPTH);
        chk("R10", "more cleared", int'(st_more), 0);

        for (int i = 0; i < 7; i++) op_wr(0, hdr_byte(i, 10));
        op_ctl(0, GO);
        chk("R6", "go with more-expected ignored", int'(st_state), 2);
        chk("R6", "no request while expecting", int'(be_req), 0);
        op_ctl(0, CR);

        send_cmd(0, 8);
        op_ctl(0, GO);
        op_ctl(0, CR);
        chk("R10", "cancel pulse", int'(be_cancel), 1);
        chk("R10", "still executing", int'(st_state), 3);
        op_wr(0, 8'hAA);
        chk("R3", "exec write dropped", int'(st_state), 3);
        make_resp(8);
        backend(8, 1'b0);
        chk("R10", "abort done to ready", int'(st_state), 1);
        chk("R10", "no avail after abort", int'(st_avail), 0);
        chk("R10", "cready after abort", int'(st_cready), 1);

        op_ctl(2, CR);
        for (int i = 0; i < DEPTH; i++) op_wr(2, hdr_byte(i, 32'h0000FFFF));
        chk("R5", "still expecting when full", int'(st_more), 1);
        chk("R5", "no space left", int'(burst_cnt), 0);
        op_wr(2, 8'h11);
        chk("R5", "overflow clears more", int'(st_more), 0);
        chk("R5", "overflow keeps valid", int'(st_valid), 1);
        op_ctl(2, GO);
        chk("R6", "length at full", int'(be_len), DEPTH);
        make_resp(12);
        backend(12, 1'b1);
        chk("R13", "selftest set", int'(st_selftest), 1);
        op_wr(2, 8'h22);
        chk("R3", "completion write dropped", int'(st_avail), 1);
        chk("R3", "completion burst unchanged", int'(burst_cnt), 12);
        read_resp(2, 12, "R8");
        op_ctl(2, CR);
        exp_state[2] = 1;
        chk("R13", "selftest survives", int'(st_selftest), 1);
        chk("R13", "family survives", int'(st_family), int'(FAM));
        host_loc = 3'd4; #1;
        chk("R13", "selftest in other locality", int'(st_selftest), 1);

        for (int k = 0; k < 25; k++) begin
            full_cycle(int'($urandom_range(0, NLOC - 1)), int'($urandom_range(6, 48)),
                       int'($urandom_range(6, 48)), 1'($urandom_range(0, 1)), 1'b0);
        end
        host_loc = 3'd3; #1;
        chk("R13", "selftest after traffic", int'(st_selftest), 1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule